// File: doc/BRIEF.md
# Serial Flash Pin Owner and Whole-Chip Erase Engine

This block decides who drives the serial flash pins. Three parties can do so: the hardware access engine, software toggling the pins directly, and a built-in sequencer that erases the whole device. Software asks for the pins with a request bit and may only toggle them once its grant reads 1. The hardware engine's own pin requests are then held off until software lets go. Whenever the owner changes, chip select is parked high for one clock.

A whole-device erase is armed in two steps. Software first sets an erase flag and then writes the two-bit write-enable field to 0. From then on the block needs no help from software. It waits until the pins are free and sends a write-enable byte, then the erase opcode taken from a programmable input. After that it polls the device status until the in-progress bit reads 0. A busy flag covers the whole operation so software can poll it. Per-sector erase is not offered here; software does it by toggling the pins itself.

Top module: `flash_owner_arb`

## Requirements
- R1: After reset `grant`, `busy`, `erase_flag` and `hw_hold` are 0 and the flash pins follow the hardware engine's pin inputs.
- R2: `grant` stays 0 while `hw_busy` is 1. With `hw_busy` low, no erase pending and `sw_req` high at a rising edge, `grant` reads 1 after the second rising edge.
- R3: While `grant` is 1, `spi_sck`, `spi_cs_n` and `spi_mosi` equal `sw_sck`, `sw_cs_n` and `sw_mosi`, and `hw_hold` equals `hw_req`. While the hardware engine owns the pins, they equal the `hw_*` inputs and `hw_hold` is 0.
- R4: Dropping `sw_req` clears `grant` after the next rising edge. The pins follow the `hw_*` inputs again after the edge that follows.
- R5: On every change of owner, the clock cycle between owners drives `spi_cs_n` high and `spi_sck` low.
- R6: An erase starts only when `wen_wr` writes the value 2'b00 while `erase_flag` (set by `erase_set`) is 1 and `busy` is 0; `busy` then reads 1 after the next rising edge. Writing 2'b00 with the flag clear, or any other value, leaves `busy` at 0.
- R7: The erase sends frames with chip select low, MSB first, with data valid on rising `spi_sck`. The frames are an 8-bit 0x06, then an 8-bit `erase_op`, then 16-bit frames of 0x05 followed by an 8-bit status byte read from `spi_miso`. The status frame repeats while the last status bit (bit 0) is 1.
- R8: `busy` stays 1 until a status frame returns bit 0 equal to 0. In that cycle `busy` and `erase_flag` both clear.
- R9: No grant is issued while an erase is pending or running. A request held across the erase is granted after it ends.
- R10: An erase armed while software holds the grant leaves the pins with software and starts only after `sw_req` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sw_req | input | 1 | Software request for direct pin control |
| sw_sck | input | 1 | Software-driven serial clock |
| sw_cs_n | input | 1 | Software-driven chip select |
| sw_mosi | input | 1 | Software-driven data out |
| hw_req | input | 1 | Hardware engine wants the pins |
| hw_busy | input | 1 | Hardware engine access in progress |
| hw_sck | input | 1 | Hardware engine serial clock |
| hw_cs_n | input | 1 | Hardware engine chip select |
| hw_mosi | input | 1 | Hardware engine data out |
| erase_set | input | 1 | Pulse: set the erase flag |
| wen_wr | input | 1 | Pulse: write the write-enable field |
| wen_val | input | 2 | Value written to the write-enable field |
| erase_op | input | 8 | Erase opcode |
| spi_miso | input | 1 | Data in from the flash |
| grant | output | 1 | Software owns the pins |
| hw_hold | output | 1 | Hardware engine request is held off |
| busy | output | 1 | Erase pending or running |
| erase_flag | output | 1 | Erase flag state |
| spi_sck | output | 1 | Flash serial clock |
| spi_cs_n | output | 1 | Flash chip select |
| spi_mosi | output | 1 | Flash data out |

## Verification
The bench keeps `sw_req` high through a whole erase. A design that granted early would let software corrupt the erase frames. It also arms an erase while software holds the pins; a wrong design would start driving the pins under software. Status polling runs with the in-progress bit held at 1 for several frames before it drops. A design that stopped after one poll, or checked the wrong status bit, would clear `busy` too early. The tests also cover the cycle between owners and arming with a wrong field value or with the flag clear. A missing cycle between owners would glue two frames together, and a loose trigger would start a stray erase.

// File: rtl/flash_owner_arb.sv
module flash_owner_arb #(
  parameter int          SCK_HALF  = 2,
  parameter logic [7:0]  WREN_CODE = 8'h06,
  parameter logic [7:0]  RDSR_CODE = 8'h05
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_req,
  input  logic       sw_sck,
  input  logic       sw_cs_n,
  input  logic       sw_mosi,
  input  logic       hw_req,
  input  logic       hw_busy,
  input  logic       hw_sck,
  input  logic       hw_cs_n,
  input  logic       hw_mosi,
  input  logic       erase_set,
  input  logic       wen_wr,
  input  logic [1:0] wen_val,
  input  logic [7:0] erase_op,
  input  logic       spi_miso,
  output logic       grant,
  output logic       hw_hold,
  output logic       busy,
  output logic       erase_flag,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi
);
  localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(SCK_HALF - 1);

  typedef enum logic [1:0] {O_HW, O_GAP, O_SW, O_ER} own_t;
  typedef enum logic [1:0] {E_IDLE, E_XFER, E_CSH} est_t;

  own_t owner, gap_to;
  est_t es;
  logic [1:0] step;
  logic rd_ph;
  logic [7:0] sh, rx, op_q;
  logic [2:0] bitn;
  logic [CW-1:0] cnt;
  logic e_sck, e_cs_n;
  logic trig, e_start, e_done;

  assign trig    = erase_flag && wen_wr && (wen_val == 2'b00) && !busy;
  assign e_start = (owner == O_GAP) && (gap_to == O_ER);
  assign e_done  = (es == E_CSH) && (step == 2'd2) && !rx[0];
  assign grant   = (owner == O_SW);
  assign hw_hold = hw_req && (owner != O_HW);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      erase_flag <= 1'b0;
    end else begin
      if (trig) busy <= 1'b1;
      else if (e_done) busy <= 1'b0;
      if (e_done) erase_flag <= 1'b0;
      else if (erase_set) erase_flag <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      owner <= O_HW;
      gap_to <= O_HW;
    end else begin
      case (owner)
        O_HW:
          if (busy && !hw_busy) begin
            owner <= O_GAP; gap_to <= O_ER;
          end else if (sw_req && !busy && !trig && !hw_busy) begin
            owner <= O_GAP; gap_to <= O_SW;
          end
        O_GAP: owner <= gap_to;
        O_SW:
          if (!sw_req) begin
            owner <= O_GAP; gap_to <= O_HW;
          end
        O_ER:
          if (e_done) begin
            owner <= O_GAP; gap_to <= O_HW;
          end
        default: owner <= O_HW;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      es <= E_IDLE;
      step <= 2'd0;
      rd_ph <= 1'b0;
      sh <= 8'h00;
      rx <= 8'h00;
      op_q <= 8'h00;
      bitn <= 3'd0;
      cnt <= '0;
      e_sck <= 1'b0;
      e_cs_n <= 1'b1;
    end else begin
      case (es)
        E_IDLE: begin
          e_cs_n <= 1'b1;
          e_sck <= 1'b0;
          if (e_start) begin
            es <= E_XFER; step <= 2'd0; sh <= WREN_CODE; bitn <= 3'd7;
            cnt <= '0; rd_ph <= 1'b0; e_cs_n <= 1'b0; op_q <= erase_op;
          end
        end
        E_XFER:
          if (cnt == CNT_TOP) begin
            cnt <= '0;
            e_sck <= !e_sck;
            if (!e_sck) rx <= {rx[6:0], spi_miso};
            else if (bitn != 3'd0) begin
              bitn <= bitn - 3'd1;
              sh <= {sh[6:0], 1'b0};
            end else if (step == 2'd2 && !rd_ph) begin
              rd_ph <= 1'b1; bitn <= 3'd7; sh <= 8'h00;
            end else begin
              es <= E_CSH; e_cs_n <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        E_CSH: begin
          es <= E_XFER; bitn <= 3'd7; cnt <= '0; e_cs_n <= 1'b0; rd_ph <= 1'b0;
          case (step)
            2'd0: begin step <= 2'd1; sh <= op_q; end
            2'd1: begin step <= 2'd2; sh <= RDSR_CODE; end
            default:
              if (rx[0]) sh <= RDSR_CODE;
              else begin es <= E_IDLE; e_cs_n <= 1'b1; end
          endcase
        end
        default: es <= E_IDLE;
      endcase
    end

  always_comb begin
    case (owner)
      O_SW:    begin spi_sck = sw_sck; spi_cs_n = sw_cs_n; spi_mosi = sw_mosi; end
      O_ER:    begin spi_sck = e_sck;  spi_cs_n = e_cs_n;  spi_mosi = sh[7];   end
      O_GAP:   begin spi_sck = 1'b0;   spi_cs_n = 1'b1;    spi_mosi = 1'b0;    end
      default: begin spi_sck = hw_sck; spi_cs_n = hw_cs_n; spi_mosi = hw_mosi; end
    endcase
  end

  p_gap_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> $past(spi_cs_n));
  p_no_grant_erase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (es != E_IDLE) |-> !grant);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && hw_req) |-> hw_hold);
  p_busy_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (es != E_IDLE) |-> busy);
  p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !erase_flag);
  p_trig_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_flag && wen_wr && wen_val == 2'b00 && !busy) |=> busy);
endmodule

// File: tb/test_flash_owner_arb.sv
module test_flash_owner_arb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_req = 0, sw_sck = 0, sw_cs_n = 1, sw_mosi = 0;
  logic hw_req = 0, hw_busy = 0, hw_sck = 0, hw_cs_n = 1, hw_mosi = 0;
  logic erase_set = 0, wen_wr = 0;
  logic [1:0] wen_val = 2'b11;
  logic [7:0] erase_op = 8'hC7;
  logic spi_miso = 1'b0;
  logic grant, hw_hold, busy, erase_flag, spi_sck, spi_cs_n, spi_mosi;
  int errors = 0, checks = 0;
  logic done = 1'b0;

  flash_owner_arb i_flash_owner_arb (.*);

  always #2 clk = ~clk;

  logic mon_en = 1'b0;
  int nfr = 0, clen = 0;
  logic [15:0] curo, curi;
  logic [15:0] fo [0:63];
  logic [15:0] fi [0:63];
  int flen [0:63];

  always @(posedge spi_sck) if (mon_en && !spi_cs_n) begin
    curo = {curo[14:0], spi_mosi};
    curi = {curi[14:0], spi_miso};
    clen = clen + 1;
  end
  always @(posedge spi_cs_n) if (mon_en && clen > 0) begin
    if (nfr < 64) begin fo[nfr] = curo; fi[nfr] = curi; flen[nfr] = clen; end
    nfr = nfr + 1;
    clen = 0;
  end

  function automatic logic [7:0] exp_cmd(input int idx, input logic [7:0] op);
    return (idx == 0) ? 8'h06 : (idx == 1) ? op : 8'h05;
  endfunction
  function automatic int exp_len(input int idx);
    return (idx < 2) ? 8 : 16;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic arm_write(input logic [1:0] v);
    wen_val = v; wen_wr = 1; tick(); wen_wr = 0;
  endtask

  task automatic check_frames(input string tag, input logic [7:0] op, input int min_polls);
    chk({tag, " frame count"}, 32'(nfr >= 2 + min_polls), 1);
    for (int f = 0; f < nfr && f < 64; f++) begin
      chk({tag, " frame len"}, flen[f], exp_len(f));
      if (f < 2) chk({tag, " cmd byte"}, fo[f][7:0], exp_cmd(f, op));
      else begin
        chk({tag, " poll byte"}, fo[f][15:8], exp_cmd(f, op));
        chk({tag, " status bit0"}, fi[f][0], (f == nfr - 1) ? 1'b0 : 1'b1);
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int waitc;
    logic [7:0] op;
    void'($urandom(32'd20240611));
    hw_req = 1; hw_cs_n = 1;
    tick(3);
    // R1 reset state
    chk("R1 grant", grant, 0);
    chk("R1 busy", busy, 0);
    chk("R1 erase_flag", erase_flag, 0);
    chk("R1 cs_n", spi_cs_n, 1);
    rst_n = 1; tick();
    chk("R1 hw_hold", hw_hold, 0);
    hw_cs_n = 0; hw_mosi = 1; #1;
    chk("R1 pins follow hw", {spi_cs_n, spi_mosi}, 2'b01);
    hw_cs_n = 1; hw_mosi = 0; hw_req = 0;

    // R2 blocked by hw_busy
    hw_busy = 1; sw_req = 1;
    tick(10);
    chk("R2 no grant while hw_busy", grant, 0);
    hw_busy = 0; tick();
    chk("R5 gap cs high", spi_cs_n, 1);
    chk("R5 gap sck low", spi_sck, 0);
    chk("R2 grant not yet", grant, 0);
    tick();
    chk("R2 grant after two edges", grant, 1);

    // R3 random pins while granted
    for (int i = 0; i < 200; i++) begin
      sw_sck = $urandom; sw_cs_n = $urandom; sw_mosi = $urandom;
      hw_sck = $urandom; hw_cs_n = $urandom; hw_mosi = $urandom; hw_req = $urandom;
      #1;
      chk("R3 sw pins", {spi_sck, spi_cs_n, spi_mosi}, {sw_sck, sw_cs_n, sw_mosi});
      chk("R3 hold", hw_hold, hw_req);
      tick();
    end
    hw_req = 0; sw_cs_n = 1; sw_sck = 0; hw_cs_n = 1; hw_sck = 0;

    // R4 release
    sw_req = 0; tick();
    chk("R4 grant drops", grant, 0);
    chk("R5 release gap cs", spi_cs_n, 1);
    tick();
    for (int i = 0; i < 100; i++) begin
      hw_sck = $urandom; hw_cs_n = $urandom; hw_mosi = $urandom; hw_req = $urandom;
      #1;
      chk("R3 hw pins", {spi_sck, spi_cs_n, spi_mosi}, {hw_sck, hw_cs_n, hw_mosi});
      chk("R3 no hold under hw", hw_hold, 0);
      tick();
    end
    hw_req = 0; hw_cs_n = 1; hw_sck = 0; hw_mosi = 0;

    // R6 ignored trigger attempts
    arm_write(2'b00); tick();
    chk("R6 no flag no start", busy, 0);
    chk("R6 pins stay hw", spi_cs_n, hw_cs_n);
    erase_set = 1; tick(); erase_set = 0;
    chk("R6 flag set", erase_flag, 1);
    arm_write(2'b01); tick();
    chk("R6 wrong value no start", busy, 0);
    arm_write(2'b10); tick();
    chk("R6 wrong value 2 no start", busy, 0);

    // R6/R7/R8/R9 erase with long polling and held request
    op = 8'($urandom); erase_op = op;
    spi_miso = 1; mon_en = 1; nfr = 0; clen = 0;
    wen_val = 2'b00; wen_wr = 1; tick(); wen_wr = 0;
    chk("R6 busy after trigger", busy, 1);
    sw_req = 1;
    waitc = 0;
    for (int i = 0; i < 600; i++) begin
      if (grant) waitc++;
      tick();
    end
    chk("R9 no grant during erase", waitc, 0);
    chk("R8 busy held while in progress", busy, 1);
    spi_miso = 0;
    waitc = 0;
    while (busy && waitc < 2000) begin
      if (grant) chk("R9 grant during erase", grant, 0);
      tick(); waitc++;
    end
    chk("R8 busy clears", busy, 0);
    chk("R8 flag clears", erase_flag, 0);
    tick(2);
    mon_en = 0;
    check_frames("R7", op, 2);
    waitc = 0;
    while (!grant && waitc < 20) begin tick(); waitc++; end
    chk("R9 held request granted", grant, 1);

    // R10 arm during grant
    erase_set = 1; tick(); erase_set = 0;
    arm_write(2'b00);
    chk("R10 busy", busy, 1);
    for (int i = 0; i < 50; i++) begin
      sw_sck = $urandom; sw_mosi = $urandom; sw_cs_n = $urandom; #1;
      chk("R10 pins stay sw", {spi_sck, spi_cs_n, spi_mosi}, {sw_sck, sw_cs_n, sw_mosi});
      tick();
    end
    sw_cs_n = 1; sw_sck = 0;
    op = 8'($urandom); erase_op = op;
    mon_en = 1; nfr = 0; clen = 0; spi_miso = 0;
    sw_req = 0;
    waitc = 0;
    while (busy && waitc < 2000) begin tick(); waitc++; end
    chk("R10 erase completes", busy, 0);
    tick(2);
    mon_en = 0;
    check_frames("R10", op, 1);
    chk("R10 grant off", grant, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule